// File: doc/BRIEF.md
# I2C Master Bit Engine

This block is the bit-level core of an I2C master. On a one-cycle command it produces a START (plain or repeated), a STOP, a byte write or a byte read on open-drain SCL and SDA lines. Each line is modelled as an output enable, where 1 pulls the wire low, together with a sampled input that returns the resolved wired-AND level. A byte write sends eight data bits most significant first, then releases SDA for a ninth clock and records the acknowledge. A byte read shifts eight bits in and then drives the acknowledge bit that the caller requested.

SCL timing comes from two run-time period inputs counted in system clock cycles: one for the low phase and one for the high phase. Setting them separately fixes both the bus rate and the duty cycle. With a 50 MHz clock, rates of 100 kHz, 400 kHz and 1 MHz can be reached. The high-phase count waits until SCL is actually seen high, so a device that holds the clock low lengthens the low phase. While writing data, the engine compares the SDA level it released against the level on the bus. If another master pulls SDA low, the engine drops the transfer and lets go of both lines.

Top module: `i2c_bit_master`

## Requirements
- R1: After reset, scl_oe, sda_oe, busy, done, got_nack and arb_lost are all 0.
- R2: A command is accepted only when busy is 0 and cmd_valid is 1. The encodings are 0 START, 1 STOP, 2 WRITE and 3 READ. busy is 1 from the next cycle until the operation ends. cmd_valid is ignored while busy is 1.
- R3: Every low phase drives scl_oe to 1 for exactly low_len cycles. Every high phase releases SCL and, once SCL reads high, lasts exactly high_len cycles. Both periods must be at least 2.
- R4: While scl_in reads 0 during a high phase, the high-phase count does not advance, so a stretched clock lengthens the phase by the number of held cycles.
- R5: START is a low phase with SDA released, then a high phase with SDA released, then a further high period with SDA pulled low. STOP is a low phase with SDA low, then a high phase with SDA low, then a further high period with SDA released. START issued after a byte gives a repeated START.
- R6: sda_oe keeps its previous value in the first cycle of each low phase and takes the new bit from the second cycle. Inside a byte operation it never changes while SCL is released. Between operations it holds its last value.
- R7: WRITE sends wr_data most significant bit first, with sda_oe equal to the inverted bit, and releases SDA on the ninth clock. got_nack is cleared when a WRITE is accepted and is loaded with sda_in on the last high cycle of the ninth clock.
- R8: READ keeps SDA released for eight clocks and shifts sda_in into rd_data, most significant bit first, on the last high cycle of each clock. On the ninth clock sda_oe equals rd_ack.
- R9: During a data bit of a WRITE, a high-phase cycle in which SDA is released, scl_in is 1 and sda_in is 0 ends the operation. On the next cycle busy, scl_oe and sda_oe are 0 and arb_lost is 1. arb_lost is cleared at the next accepted command.
- R10: done is a one-cycle pulse in the cycle after an operation ends, whether it completed or was stopped by arbitration. busy is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| high_len | input | PW | SCL high period in clock cycles |
| low_len | input | PW | SCL low period in clock cycles |
| cmd_valid | input | 1 | Command strobe |
| cmd | input | 2 | 0 START, 1 STOP, 2 WRITE, 3 READ |
| wr_data | input | 8 | Byte to send on WRITE |
| rd_ack | input | 1 | 1 to acknowledge (drive low) after READ |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| rd_data | output | 8 | Byte received by READ |
| got_nack | output | 1 | Ninth bit of last WRITE read high |
| arb_lost | output | 1 | Last WRITE lost arbitration |
| scl_oe | output | 1 | Pull SCL low |
| scl_in | input | 1 | Resolved SCL level |
| sda_oe | output | 1 | Pull SDA low |
| sda_in | input | 1 | Resolved SDA level |

## Verification
The properties assume that high_len and low_len are at least 2 and stay fixed while an operation runs. They also assume that SDA and SCL reach the engine only as the wired-AND of its own enables and those of other devices. The stimulus changes the periods only between operations. It builds both lines as that wired-AND in the bench. Other devices pull SDA only from the start of a low phase through the matching high phase, and stretch SCL only at the start of a high phase.

// File: rtl/i2c_bit_master.sv
module i2c_bit_master #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] high_len,
  input  logic [PW-1:0] low_len,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd,
  input  logic [7:0]    wr_data,
  input  logic          rd_ack,
  output logic          busy,
  output logic          done,
  output logic [7:0]    rd_data,
  output logic          got_nack,
  output logic          arb_lost,
  output logic          scl_oe,
  input  logic          scl_in,
  output logic          sda_oe,
  input  logic          sda_in
);

  localparam logic [1:0] OP_START = 2'd0;
  localparam logic [1:0] OP_STOP  = 2'd1;
  localparam logic [1:0] OP_WRITE = 2'd2;
  localparam logic [1:0] OP_READ  = 2'd3;
  localparam logic [4:0] BYTE_LAST = 5'd17;
  localparam logic [4:0] COND_LAST = 5'd2;

  logic [1:0]    op;
  logic [4:0]    step;
  logic [PW-1:0] cnt;
  logic [7:0]    tx;
  logic          ack_q;
  logic          sda_hold;
  logic [3:0]    bitn;
  logic          hi, last_step, want, first_low, seg_end, arb_hit;

  assign bitn      = step[4:1];
  assign hi        = op[1] ? step[0] : (step != 5'd0);
  assign last_step = op[1] ? (step == BYTE_LAST) : (step == COND_LAST);
  assign first_low = !hi && (cnt == '0);
  assign seg_end   = hi ? (scl_in && cnt == high_len - PW'(1)) : (cnt == low_len - PW'(1));

  always_comb begin
    case (op)
      OP_START: want = (step == 5'd2);
      OP_STOP:  want = (step != 5'd2);
      OP_WRITE: want = (bitn < 4'd8) ? ~tx[~bitn[2:0]] : 1'b0;
      default:  want = (bitn == 4'd8) && ack_q;
    endcase
  end

  assign arb_hit = busy && op == OP_WRITE && hi && bitn < 4'd8 && scl_in && !want && !sda_in;
  assign scl_oe  = busy && !hi;
  assign sda_oe  = (busy && !first_low) ? want : sda_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      op       <= OP_START;
      step     <= '0;
      cnt      <= '0;
      tx       <= '0;
      ack_q    <= 1'b0;
      sda_hold <= 1'b0;
      rd_data  <= '0;
      got_nack <= 1'b0;
      arb_lost <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (cmd_valid) begin
          busy     <= 1'b1;
          op       <= cmd;
          step     <= '0;
          cnt      <= '0;
          tx       <= wr_data;
          ack_q    <= rd_ack;
          arb_lost <= 1'b0;
          if (cmd == OP_WRITE) got_nack <= 1'b0;
        end
      end else if (arb_hit) begin
        busy     <= 1'b0;
        done     <= 1'b1;
        arb_lost <= 1'b1;
        sda_hold <= 1'b0;
      end else begin
        sda_hold <= sda_oe;
        if (hi && !scl_in) begin
          cnt <= cnt;
        end else if (seg_end) begin
          cnt <= '0;
          if (hi && op == OP_READ && bitn < 4'd8) rd_data <= {rd_data[6:0], sda_in};
          if (hi && op == OP_WRITE && bitn == 4'd8) got_nack <= sda_in;
          if (last_step) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            step <= step + 5'd1;
          end
        end else begin
          cnt <= cnt + PW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/i2c_bit_master_chk.sv
module i2c_bit_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       scl_in,
  input logic       arb_lost,
  input logic [1:0] op
);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_arb_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> (!scl_oe && !sda_oe && !busy));

  assert_stretch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !scl_oe && !scl_in) |=> busy);

  assert_sda_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op[1] && $past(busy) && !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe));

endmodule

bind i2c_bit_master i2c_bit_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .scl_oe(scl_oe),
  .sda_oe(sda_oe), .scl_in(scl_in), .arb_lost(arb_lost), .op(op)
);

// File: tb/test_i2c_bit_master.sv
module test_i2c_bit_master;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n;
  logic [7:0] high_len, low_len, wr_data, rd_data;
  logic       cmd_valid, rd_ack, busy, done, got_nack, arb_lost;
  logic [1:0] cmd;
  logic       scl_oe, sda_oe, scl_in, sda_in;
  logic       slave_sda, slave_scl;

  assign scl_in = !(scl_oe || slave_scl);
  assign sda_in = !(sda_oe || slave_sda);

  i2c_bit_master i_i2c_bit_master (
    .clk(clk), .rst_n(rst_n), .high_len(high_len), .low_len(low_len),
    .cmd_valid(cmd_valid), .cmd(cmd), .wr_data(wr_data), .rd_ack(rd_ack),
    .busy(busy), .done(done), .rd_data(rd_data), .got_nack(got_nack),
    .arb_lost(arb_lost), .scl_oe(scl_oe), .scl_in(scl_in),
    .sda_oe(sda_oe), .sda_in(sda_in));

  int tests = 0, fails = 0;
  bit q_scl[$], q_sda[$], q_busy[$], q_done[$], s_sda[$], s_scl[$];
  bit prev_sda = 0;
  int th, tl;

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic seg(bit high, bit w, bit slv, int len, int stretch);
    for (int i = 0; i < stretch + len; i++) begin
      q_scl.push_back(!high);
      q_sda.push_back((!high && i == 0) ? prev_sda : w);
      q_busy.push_back(1);
      q_done.push_back(0);
      s_sda.push_back(slv);
      s_scl.push_back(high && i < stretch);
    end
    prev_sda = w;
  endtask

  task automatic run(input bit [1:0] c, input bit [7:0] txd, input bit ack,
                     input bit [7:0] sbyte, input bit sack, input int st_at,
                     input int st_len, input int arb_at, input bit bad);
    string rs, rd;
    int n = 0;
    rs = (st_at >= 0) ? "R4" : "R3";
    rd = (c[1] == 0) ? "R5" : (c == 2'd2 ? "R7" : "R8");
    if (c == 2'd0) begin
      seg(0, 0, 0, tl, 0); seg(1, 0, 0, th, st_at == 0 ? st_len : 0); seg(1, 1, 0, th, 0);
    end else if (c == 2'd1) begin
      seg(0, 1, 0, tl, 0); seg(1, 1, 0, th, st_at == 0 ? st_len : 0); seg(1, 0, 0, th, 0);
    end else begin
      for (int b = 0; b < 9; b++) begin
        bit w, slv;
        if (c == 2'd2) begin
          w = (b < 8) ? !txd[7-b] : 1'b0;
          slv = (b < 8) ? (b == arb_at) : sack;
        end else begin
          w = (b < 8) ? 1'b0 : ack;
          slv = (b < 8) ? !sbyte[7-b] : 1'b0;
        end
        seg(0, w, slv, tl, 0);
        if (b == arb_at) begin
          seg(1, w, 1, 1, 0);
          prev_sda = 0;
          break;
        end
        seg(1, w, slv, th, st_at == b ? st_len : 0);
      end
    end
    q_scl.push_back(0); q_sda.push_back(prev_sda); q_busy.push_back(0);
    q_done.push_back(1); s_sda.push_back(0); s_scl.push_back(0);

    @(negedge clk);
    cmd = c; wr_data = txd; rd_ack = ack; cmd_valid = 1;
    #1 chk("R2", "busy before accept", busy, 0);
    while (q_scl.size() > 0) begin
      @(negedge clk);
      n++;
      if (bad && n <= 3) begin
        cmd_valid = 1; cmd = ~c;
      end else cmd_valid = 0;
      slave_sda = s_sda.pop_front();
      slave_scl = s_scl.pop_front();
      #1;
      chk(rs, "scl_oe", scl_oe, q_scl.pop_front());
      chk(rd, "sda_oe", sda_oe, q_sda.pop_front());
      chk("R2", "busy", busy, q_busy.pop_front());
      chk("R10", "done", done, q_done.pop_front());
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      chk("R6", "idle sda_oe held", sda_oe, prev_sda);
      chk("R2", "idle busy", busy, 0);
      chk("R10", "idle done", done, 0);
      chk("R3", "idle scl_oe", scl_oe, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 0; cmd_valid = 0; cmd = 0; wr_data = 0; rd_ack = 0;
    slave_sda = 0; slave_scl = 0; high_len = 4; low_len = 6; th = 4; tl = 6;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "scl_oe", scl_oe, 0); chk("R1", "sda_oe", sda_oe, 0);
    chk("R1", "busy", busy, 0); chk("R1", "done", done, 0);
    chk("R1", "got_nack", got_nack, 0); chk("R1", "arb_lost", arb_lost, 0);
    rst_n = 1;
    idle(2);

    run(2'd0, 0, 0, 0, 0, -1, 0, -1, 0);
    run(2'd2, 8'hA5, 0, 0, 1, -1, 0, -1, 0);
    chk("R7", "got_nack after ack", got_nack, 0);
    run(2'd2, 8'h3C, 0, 0, 0, -1, 0, -1, 1);
    chk("R7", "got_nack after no ack", got_nack, 1);
    idle(3);
    run(2'd0, 0, 0, 0, 0, -1, 0, -1, 0);
    run(2'd3, 0, 1, 8'h96, 0, -1, 0, -1, 0);
    chk("R8", "rd_data", rd_data, 8'h96);
    chk("R9", "no arb on read", arb_lost, 0);

    high_len = 2; low_len = 3; th = 2; tl = 3;
    run(2'd3, 0, 0, 8'h5A, 0, -1, 0, -1, 0);
    chk("R8", "rd_data", rd_data, 8'h5A);
    run(2'd1, 0, 0, 0, 0, -1, 0, -1, 0);
    idle(2);

    high_len = 9; low_len = 3; th = 9; tl = 3;
    run(2'd0, 0, 0, 0, 0, 0, 5, -1, 0);
    run(2'd2, 8'hF0, 0, 0, 1, 3, 7, -1, 0);
    chk("R7", "got_nack", got_nack, 0);

    high_len = 4; low_len = 5; th = 4; tl = 5;
    run(2'd2, 8'hFF, 0, 0, 0, -1, 0, 2, 0);
    chk("R9", "arb_lost set", arb_lost, 1);
    idle(2);
    run(2'd0, 0, 0, 0, 0, -1, 0, -1, 0);
    chk("R9", "arb_lost cleared", arb_lost, 0);
    run(2'd1, 0, 0, 0, 0, -1, 0, -1, 0);
    idle(2);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule